// File: doc/BRIEF.md
# Fault Escalation Controller

This block decides how a fault reported by a CPU core is delivered. Every report raises a nested-fault count. The first fault in a nest is delivered with its own vector. Any later fault is delivered as a double fault on vector 8. A third nested fault delivers nothing and instead asks for a core reset.

For each delivery, the block first pulses two requests: one restores the instruction pointer from its saved copy, and one clears prefix state. It then requests a gate dispatch and waits for the dispatch unit to answer. If the vector carries an error code and protected mode is on, the block then requests an error-code push and waits for the push unit to answer.

A failed dispatch or push returns the block to idle with the count kept. The failure is itself reported back as a new fault, so it escalates. The count clears only when a delivery completes in full.

Top module: `fault_escalator`

## Requirements
- R1: After reset the block is idle: busy low, all request outputs low, nest count 0.
- R2: A fault report accepted while idle raises the nest count by one.
- R3: When the raised count exceeds 1, the delivered vector is 8 regardless of the reported vector.
- R4: When the raised count is 1, the delivered vector equals the reported vector.
- R5: When the raised count would reach 3, core_reset_req pulses for exactly one cycle, no restore, prefix clear or dispatch request is made, the count returns to 0 and the block stays idle.
- R6: ip_restore and prefix_clear pulse together for one cycle right after acceptance, and disp_req rises only in the following cycle.
- R7: A dispatch completion with disp_ok low returns the block to idle with the nest count unchanged.
- R8: push_req is raised after a successful dispatch only when the delivered vector is one of 8, 10, 11, 12, 13, 14 or 17 and prot_mode was high at acceptance; push_code carries the reported error code.
- R9: After the dispatch and any required push both succeed, busy stays high for one further cycle, then the block is idle with nest count 0.
- R10: fault_valid is ignored while busy is high.
- R11: A push completion with push_ok low returns the block to idle with the nest count unchanged.
- R12: busy is high exactly while the block is not idle, and disp_req or push_req are only ever high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault report strobe |
| fault_vector | input | 8 | Reported vector number |
| fault_code | input | 32 | Reported error code |
| prot_mode | input | 1 | Protected mode enabled |
| disp_done | input | 1 | Dispatch unit finished |
| disp_ok | input | 1 | Dispatch succeeded, valid with disp_done |
| push_done | input | 1 | Push unit finished |
| push_ok | input | 1 | Push succeeded, valid with push_done |
| busy | output | 1 | Delivery in progress |
| ip_restore | output | 1 | Restore instruction pointer from saved copy |
| prefix_clear | output | 1 | Clear prefix state |
| disp_req | output | 1 | Dispatch request, held until disp_done |
| disp_vector | output | 8 | Vector to dispatch |
| push_req | output | 1 | Error-code push request, held until push_done |
| push_code | output | 32 | Error code to push |
| core_reset_req | output | 1 | One-cycle core reset request |
| nest_count | output | 2 | Current nested-fault count |

## Verification
A new fault report can arrive in the same cycle that the dispatch unit signals completion. It can also arrive in the same cycle as the preparation pulses. The bench drives fault_valid together with disp_done, and separately during the restore cycle. The case is judged correct if the nest count is unchanged and no second restore pulse appears. The block must also return to idle without going busy again, so a report is never counted twice or half-accepted.

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 32,
  parameter int DF_VEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_valid,
  input  logic [VEC_W-1:0] fault_vector,
  input  logic [ERR_W-1:0] fault_code,
  input  logic             prot_mode,
  input  logic             disp_done,
  input  logic             disp_ok,
  input  logic             push_done,
  input  logic             push_ok,
  output logic             busy,
  output logic             ip_restore,
  output logic             prefix_clear,
  output logic             disp_req,
  output logic [VEC_W-1:0] disp_vector,
  output logic             push_req,
  output logic [ERR_W-1:0] push_code,
  output logic             core_reset_req,
  output logic [1:0]       nest_count
);

  typedef enum logic [1:0] {IDLE, DISPATCH, PUSH_ERR, DONE} st_t;

  st_t              state;
  logic [1:0]       cnt;
  logic [1:0]       cnt_inc;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_pick;
  logic [ERR_W-1:0] err_q;
  logic             push_q;
  logic             prep_q;
  logic             rst_q;

  function automatic logic has_code(input logic [VEC_W-1:0] v);
    case (v)
      VEC_W'(8), VEC_W'(10), VEC_W'(11), VEC_W'(12),
      VEC_W'(13), VEC_W'(14), VEC_W'(17): has_code = 1'b1;
      default: has_code = 1'b0;
    endcase
  endfunction

  assign cnt_inc  = cnt + 2'd1;
  assign vec_pick = (cnt_inc > 2'd1) ? VEC_W'(DF_VEC) : fault_vector;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      cnt    <= 2'd0;
      vec_q  <= '0;
      err_q  <= '0;
      push_q <= 1'b0;
      prep_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      prep_q <= 1'b0;
      rst_q  <= 1'b0;
      case (state)
        IDLE: if (fault_valid) begin
          if (cnt_inc == 2'd3) begin
            rst_q <= 1'b1;
            cnt   <= 2'd0;
          end else begin
            cnt    <= cnt_inc;
            vec_q  <= vec_pick;
            err_q  <= fault_code;
            push_q <= has_code(vec_pick) && prot_mode;
            prep_q <= 1'b1;
            state  <= DISPATCH;
          end
        end
        DISPATCH: if (!prep_q && disp_done) begin
          if (!disp_ok)    state <= IDLE;
          else if (push_q) state <= PUSH_ERR;
          else             state <= DONE;
        end
        PUSH_ERR: if (push_done) state <= push_ok ? DONE : IDLE;
        DONE: begin
          cnt   <= 2'd0;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy           = (state != IDLE);
  assign ip_restore     = prep_q;
  assign prefix_clear   = prep_q;
  assign disp_req       = (state == DISPATCH) && !prep_q;
  assign disp_vector    = vec_q;
  assign push_req       = (state == PUSH_ERR);
  assign push_code      = err_q;
  assign core_reset_req = rst_q;
  assign nest_count     = cnt;

  a_r6_prep_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    ip_restore |-> (prefix_clear && !disp_req) ##1 disp_req);

  a_r5_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_req |-> (!busy && !ip_restore && nest_count == 2'd0));

  a_r5_never_three: assert property (@(posedge clk) disable iff (!rst_n)
    nest_count != 2'd3);

  a_r2_count_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> nest_count == $past(nest_count) + 2'd1);

  a_r3_double_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && nest_count > 2'd1) |-> disp_vector == VEC_W'(DF_VEC));

  a_r8_push_vector: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> has_code(disp_vector));

  a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req || push_req) |-> busy);

  a_r10_stable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(disp_vector));

endmodule

// File: tb/fault_escalator_tb.sv
module fault_escalator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_valid = 1'b0;
  logic [7:0] fault_vector = '0;
  logic [31:0] fault_code = '0;
  logic prot_mode = 1'b0;
  logic disp_done = 1'b0, disp_ok = 1'b0, push_done = 1'b0, push_ok = 1'b0;
  logic busy, ip_restore, prefix_clear, disp_req, push_req, core_reset_req;
  logic [7:0] disp_vector;
  logic [31:0] push_code;
  logic [1:0] nest_count;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  fault_escalator dut_i (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_vector(fault_vector),
    .fault_code(fault_code), .prot_mode(prot_mode), .disp_done(disp_done), .disp_ok(disp_ok),
    .push_done(push_done), .push_ok(push_ok), .busy(busy), .ip_restore(ip_restore),
    .prefix_clear(prefix_clear), .disp_req(disp_req), .disp_vector(disp_vector),
    .push_req(push_req), .push_code(push_code), .core_reset_req(core_reset_req),
    .nest_count(nest_count));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [7:0] v, input logic [31:0] c, input logic p);
    fault_valid = 1'b1; fault_vector = v; fault_code = c; prot_mode = p;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic answer_disp(input logic ok);
    disp_done = 1'b1; disp_ok = ok;
    @(negedge clk);
    disp_done = 1'b0; disp_ok = 1'b0;
  endtask

  task automatic answer_push(input logic ok);
    push_done = 1'b1; push_ok = ok;
    @(negedge clk);
    push_done = 1'b0; push_ok = 1'b0;
  endtask

  task automatic start(input logic [7:0] v, input logic [31:0] c, input logic p,
                       input logic [1:0] cnt_exp, input logic [7:0] vec_exp);
    fire(v, c, p);
    chk("R2 count", nest_count, cnt_exp);
    chk("R6 restore", ip_restore, 1);
    chk("R6 prefix", prefix_clear, 1);
    chk("R6 no req yet", disp_req, 0);
    @(negedge clk);
    chk("R6 restore once", ip_restore, 0);
    chk("R6 req", disp_req, 1);
    chk("R3/R4 vector", disp_vector, vec_exp);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 disp_req", disp_req, 0);
    chk("R1 push_req", push_req, 0);
    chk("R1 reset_req", core_reset_req, 0);
    chk("R1 restore", ip_restore, 0);
    chk("R1 count", nest_count, 0);
  endtask

  task automatic t_plain;
    start(8'd3, 32'h11, 1'b1, 2'd1, 8'd3);
    answer_disp(1'b1);
    chk("R8 no push vec3", push_req, 0);
    chk("R9 done busy", busy, 1);
    @(negedge clk);
    chk("R9 idle", busy, 0);
    chk("R9 count clear", nest_count, 0);
  endtask

  task automatic t_push_ok;
    start(8'd13, 32'hDEAD_BEEF, 1'b1, 2'd1, 8'd13);
    answer_disp(1'b1);
    chk("R8 push", push_req, 1);
    chk("R8 code", push_code, 32'hDEAD_BEEF);
    chk("R12 busy", busy, 1);
    answer_push(1'b1);
    chk("R9 done", push_req, 0);
    @(negedge clk);
    chk("R9 count clear push", nest_count, 0);
    chk("R12 idle", busy, 0);
  endtask

  task automatic t_real_mode;
    start(8'd13, 32'h5, 1'b0, 2'd1, 8'd13);
    answer_disp(1'b1);
    chk("R8 no push real", push_req, 0);
    @(negedge clk);
    chk("R9 real count", nest_count, 0);
  endtask

  task automatic t_triple;
    start(8'd14, 32'h2, 1'b1, 2'd1, 8'd14);
    answer_disp(1'b0);
    chk("R7 idle", busy, 0);
    chk("R7 count kept", nest_count, 1);
    start(8'd6, 32'h3, 1'b1, 2'd2, 8'd8);
    answer_disp(1'b0);
    chk("R7 count kept 2", nest_count, 2);
    fire(8'd5, 32'h0, 1'b1);
    chk("R5 reset req", core_reset_req, 1);
    chk("R5 no restore", ip_restore, 0);
    chk("R5 idle", busy, 0);
    chk("R5 count zero", nest_count, 0);
    @(negedge clk);
    chk("R5 one pulse", core_reset_req, 0);
    chk("R5 no dispatch", disp_req, 0);
  endtask

  task automatic t_push_fail;
    start(8'd10, 32'h77, 1'b1, 2'd1, 8'd10);
    answer_disp(1'b1);
    chk("R8 push 10", push_req, 1);
    answer_push(1'b0);
    chk("R11 idle", busy, 0);
    chk("R11 count kept", nest_count, 1);
    start(8'd4, 32'h99, 1'b0, 2'd2, 8'd8);
    answer_disp(1'b1);
    chk("R8 df real no push", push_req, 0);
    @(negedge clk);
    chk("R9 after df", nest_count, 0);
  endtask

  task automatic t_overlap;
    fire(8'd2, 32'h1, 1'b0);
    fault_valid = 1'b1;
    @(negedge clk);
    fault_valid = 1'b0;
    chk("R10 prep overlap count", nest_count, 1);
    chk("R10 no second restore", ip_restore, 0);
    fault_valid = 1'b1;
    answer_disp(1'b1);
    fault_valid = 1'b0;
    chk("R10 count same cycle", nest_count, 1);
    @(negedge clk);
    chk("R10 idle", busy, 0);
    chk("R10 count clear", nest_count, 0);
    @(negedge clk);
    chk("R10 not restarted", busy, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_push_ok();
    t_real_mode();
    t_triple();
    t_push_fail();
    t_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule